// File: doc/BRIEF.md
# Indexed Debug-Memory Read Port

This block lets software read several internal 64-bit debug memories through a small set of fixed register addresses. Software does not address the memory entry directly. It first programs a shared pointer register with a starting position and a stride. Each read of one of the memory windows then returns the entry at the pointer, and the pointer then moves forward by the stride.

The default build holds three memories. The first has 32 words and the other two have 256 words each. The data path that owns the memories fills them through a separate write port with a memory select. The register side can only read them. Read data comes out of a register one cycle after the read strobe. Read and write accesses have separate address buses, so a pointer update and a memory read can happen in the same cycle.

With a pointer of zero and a stride of one, consecutive reads walk one memory from first entry to last. If the pointer lands past the end of the selected memory, the read returns zero and sets a sticky out-of-range flag.

Top module: `idx_csr_mem_port`

## Requirements
- R1: After reset, `csr_rdata` is zero, `csr_rvalid` is low, `oor_flag` is low, and the pointer register reads back as zero.
- R2: The pointer register sits at offset 0x18. Bits [15:0] hold the position and bits [31:16] hold the stride. A write there loads both fields from `csr_wdata[31:0]`. A read of it returns bits [63:32] as zero.
- R3: The three memory windows sit at offsets 0x1000, 0x1008 and 0x1010, with 32, 256 and 256 entries of 64 bits. They are filled through the fill port with `fill_sel` values 0, 1 and 2 respectively. A read of a window returns the word stored at the current position.
- R4: After every read of a memory window, the position becomes position + stride modulo 2^16. This holds whether the read was in range or not.
- R5: A pointer write in the same cycle as a window read wins over the increment. That read still returns the entry at the position held before the write.
- R6: A read of the pointer register or of an unmapped offset leaves the pointer unchanged. A write to any offset other than 0x18 is ignored. An unmapped read returns zero.
- R7: `csr_rvalid` is high exactly in the cycle after `csr_rd` is sampled high. `csr_rdata` carries the read result in that same cycle.
- R8: A window read at a position at or beyond that memory's depth returns zero and sets `oor_flag`. The flag stays set until a pointer write clears it. If a new out-of-range read happens in the same cycle as that write, the flag stays set.
- R9: A fill write is ignored when `fill_addr` is at or beyond the selected memory's depth, or when `fill_sel` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_rd | input | 1 | Read strobe |
| csr_raddr | input | 16 | Read byte offset |
| csr_wr | input | 1 | Write strobe |
| csr_waddr | input | 16 | Write byte offset |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Registered read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after strobe |
| oor_flag | output | 1 | Sticky out-of-range read flag |
| fill_we | input | 1 | Data path write enable |
| fill_sel | input | 2 | Memory select for fill write (0..2) |
| fill_addr | input | 8 | Fill word address |
| fill_data | input | 64 | Fill word data |

## Verification
The assertions check the following on every cycle:
- the pointer step after each window read;
- the load-over-increment priority;
- pointer stability across other reads;
- the one-cycle valid timing;
- zero data and flag raising on out-of-range reads;
- the sticky flag's hold and clear rules.

Some behaviour can only be shown by the bench's scenarios:
- that each window returns the correct stored word for every entry;
- that strides and 16-bit wrap land on the right entries;
- that a read colliding with a pointer write uses the old position;
- that ignored fill writes and unmapped writes leave stored contents and the pointer untouched.

// File: rtl/idxm_pkg.sv
package idxm_pkg;
  localparam int IDX_W       = 16;
  localparam int CSR_AW      = 16;
  localparam int MEM_BASE    = 'h1000;
  localparam int MEM_STRIDE  = 8;
  localparam int PTR_OFFSET  = 'h18;

  // Next position: modular add in the pointer width.
  function automatic logic [IDX_W-1:0] step_pos(input logic [IDX_W-1:0] pos,
                                                input logic [IDX_W-1:0] stride);
    return pos + stride;
  endfunction

  // Byte offset of memory window k.
  function automatic logic [CSR_AW-1:0] window_addr(input int k);
    return CSR_AW'(MEM_BASE + MEM_STRIDE * k);
  endfunction
endpackage

// File: rtl/idxm_ptr_reg.sv
module idxm_ptr_reg
  import idxm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*IDX_W-1:0] load_val,
  input  logic               step,
  output logic [IDX_W-1:0]   pos,
  output logic [IDX_W-1:0]   stride
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      stride <= '0;
    end else if (load) begin
      pos    <= load_val[IDX_W-1:0];
      stride <= load_val[2*IDX_W-1:IDX_W];
    end else if (step) begin
      pos    <= step_pos(pos, stride);
    end
  end
endmodule

// File: rtl/idxm_ram.sv
module idxm_ram
  import idxm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 64,
  parameter int FILL_AW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [FILL_AW-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [DATA_W-1:0]  rdata,
  output logic               in_range
);
  localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] store [DEPTH];
  logic              w_ok;

  assign w_ok     = we && (32'(waddr) < DEPTH);
  assign in_range = (32'(raddr) < DEPTH);
  assign rdata    = in_range ? store[raddr[LAW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (w_ok) store[waddr[LAW-1:0]] <= wdata;
  end
endmodule

// File: rtl/idxm_rd_path.sv
module idxm_rd_path
  import idxm_pkg::*;
#(
  parameter int NMEM   = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [NMEM-1:0]   mem_hit,
  input  logic              ptr_hit,
  input  logic [DATA_W-1:0] mem_word [NMEM],
  input  logic [DATA_W-1:0] ptr_image,
  input  logic              oor_set,
  input  logic              oor_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              oor
);
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    sel_word = ptr_hit ? ptr_image : '0;
    for (int k = 0; k < NMEM; k++)
      if (mem_hit[k]) sel_word = sel_word | mem_word[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      oor    <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel_word;
      if (oor_set)      oor <= 1'b1;
      else if (oor_clr) oor <= 1'b0;
    end
  end
endmodule

// File: rtl/idx_csr_mem_port.sv
module idx_csr_mem_port
  import idxm_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DEPTH0  = 32,
  parameter int DEPTH1  = 256,
  parameter int DEPTH2  = 256,
  parameter int FILL_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_rd,
  input  logic [CSR_AW-1:0]  csr_raddr,
  input  logic               csr_wr,
  input  logic [CSR_AW-1:0]  csr_waddr,
  input  logic [DATA_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0]  csr_rdata,
  output logic               csr_rvalid,
  output logic               oor_flag,
  input  logic               fill_we,
  input  logic [1:0]         fill_sel,
  input  logic [FILL_AW-1:0] fill_addr,
  input  logic [DATA_W-1:0]  fill_data
);
  localparam int NMEM = 3;
  localparam int DEPTH_TAB [NMEM] = '{DEPTH0, DEPTH1, DEPTH2};
  localparam logic [CSR_AW-1:0] PTR_ADDR = CSR_AW'(PTR_OFFSET);

  // Named internal events, observed by the checker.
  logic [NMEM-1:0]   mem_hit;
  logic [NMEM-1:0]   mem_inr;
  logic              mem_rd_fire;
  logic              ptr_wr_fire;
  logic              ptr_rd_hit;
  logic              oor_hit;
  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  stride;
  logic [DATA_W-1:0] mem_word [NMEM];
  logic [DATA_W-1:0] ptr_image;

  assign ptr_wr_fire = csr_wr && (csr_waddr == PTR_ADDR);
  assign ptr_rd_hit  = csr_rd && (csr_raddr == PTR_ADDR);
  assign mem_rd_fire = |mem_hit;
  assign oor_hit     = |(mem_hit & ~mem_inr);
  assign ptr_image   = {{(DATA_W-2*IDX_W){1'b0}}, stride, pos};

  for (genvar g = 0; g < NMEM; g++) begin : g_mem
    assign mem_hit[g] = csr_rd && (csr_raddr == window_addr(g));
    idxm_ram #(
      .DEPTH  (DEPTH_TAB[g]),
      .DATA_W (DATA_W),
      .FILL_AW(FILL_AW)
    ) u_ram (
      .clk     (clk),
      .we      (fill_we && (fill_sel == 2'(g))),
      .waddr   (fill_addr),
      .wdata   (fill_data),
      .raddr   (pos),
      .rdata   (mem_word[g]),
      .in_range(mem_inr[g])
    );
  end

  idxm_ptr_reg u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_wr_fire),
    .load_val(csr_wdata[2*IDX_W-1:0]),
    .step    (mem_rd_fire),
    .pos     (pos),
    .stride  (stride)
  );

  idxm_rd_path #(
    .NMEM  (NMEM),
    .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (csr_rd),
    .mem_hit  (mem_hit),
    .ptr_hit  (ptr_rd_hit),
    .mem_word (mem_word),
    .ptr_image(ptr_image),
    .oor_set  (oor_hit),
    .oor_clr  (ptr_wr_fire),
    .rdata    (csr_rdata),
    .rvalid   (csr_rvalid),
    .oor      (oor_flag)
  );
endmodule

// File: rtl/idxm_checks.sv
module idxm_checks
  import idxm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_rd,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              csr_rvalid,
  input logic              oor_flag,
  input logic [IDX_W-1:0]  pos,
  input logic [IDX_W-1:0]  stride,
  input logic              mem_rd_fire,
  input logic              ptr_wr_fire,
  input logic              ptr_rd_hit,
  input logic              oor_hit
);
  a_r4_pos_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_fire && !ptr_wr_fire) |=> (pos == IDX_W'($past(pos) + $past(stride))));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_fire |=> ({stride, pos} == $past(csr_wdata[2*IDX_W-1:0])));

  a_r6_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_fire && !ptr_wr_fire) |=> ($stable(pos) && $stable(stride)));

  a_r6_ptr_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rd_hit && !ptr_wr_fire) |=> $stable(pos));

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> csr_rvalid);

  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> !csr_rvalid);

  a_r8_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oor_hit |=> (csr_rdata == '0 && oor_flag));

  a_r8_oor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_flag && !ptr_wr_fire) |=> oor_flag);

  a_r8_oor_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_fire && !oor_hit) |=> !oor_flag);
endmodule

bind idx_csr_mem_port idxm_checks #(.DATA_W(DATA_W)) u_idxm_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_rd     (csr_rd),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .csr_rvalid (csr_rvalid),
  .oor_flag   (oor_flag),
  .pos        (pos),
  .stride     (stride),
  .mem_rd_fire(mem_rd_fire),
  .ptr_wr_fire(ptr_wr_fire),
  .ptr_rd_hit (ptr_rd_hit),
  .oor_hit    (oor_hit)
);

// File: tb/idx_csr_mem_port_bench.sv
`timescale 1ns/1ps
module idx_csr_mem_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_rd = 1'b0;
  logic [15:0] csr_raddr = '0;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_waddr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_rvalid;
  logic        oor_flag;
  logic        fill_we = 1'b0;
  logic [1:0]  fill_sel = '0;
  logic [7:0]  fill_addr = '0;
  logic [63:0] fill_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [15:0] W0 = 16'h1000, W1 = 16'h1008, W2 = 16'h1010, PTR = 16'h0018;
  int depth [3] = '{32, 256, 256};
  logic [15:0] win [3] = '{16'h1000, 16'h1008, 16'h1010};

  always #4 clk = ~clk;

  idx_csr_mem_port u_idx_csr_mem_port (.*);

  function automatic logic [63:0] pat(input int s, input int i);
    return 64'hA5C3_0000_0000_0000 ^ (64'(s) << 48) ^ (64'(i) * 64'h0000_0100_0F0F_0011) ^ 64'(i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] s, input int a, input logic [63:0] d);
    @(negedge clk);
    fill_we = 1'b1; fill_sel = s; fill_addr = 8'(a); fill_data = d;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_waddr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic set_ptr(input int p, input int st);
    wr(PTR, {32'hCAFE_F00D, 16'(st), 16'(p)});
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_rd = 1'b1; csr_raddr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
    check("R7 rvalid after strobe", {63'b0, csr_rvalid}, 64'd1);
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", csr_rdata, 64'd0);
    check("R1 rvalid", {63'b0, csr_rvalid}, 64'd0);
    check("R1 oor", {63'b0, oor_flag}, 64'd0);
    rd(PTR, d); check("R1 pointer zero", d, 64'd0);
    @(negedge clk);
    check("R7 rvalid drops", {63'b0, csr_rvalid}, 64'd0);

    // R3 fill all memories
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < depth[s]; i++) fill(2'(s), i, pat(s, i));
    // R9 ignored fills
    fill(2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    fill(2'd0, 40, 64'h1111_2222_3333_4444);

    // R2 register layout, upper bits read zero
    wr(PTR, 64'hDEAD_BEEF_0001_0000);
    rd(PTR, d); check("R2 layout", d, 64'h0000_0000_0001_0000);

    // R3/R4 walk memory 0 with stride 1
    for (int i = 0; i < 32; i++) begin
      rd(W0, d); check("R3 walk mem0", d, pat(0, i));
    end
    check("R8 no flag in range", {63'b0, oor_flag}, 64'd0);
    // R8 past the end
    rd(W0, d); check("R8 oor data zero", d, 64'd0);
    check("R8 flag set", {63'b0, oor_flag}, 64'd1);
    rd(PTR, d); check("R4 advanced after oor read", d, {32'd0, 16'd1, 16'd33});
    check("R8 flag sticky", {63'b0, oor_flag}, 64'd1);

    // R3 walk memories 1 and 2, each after a fresh pointer write
    for (int s = 1; s < 3; s++) begin
      set_ptr(0, 1);
      check("R8 flag cleared by write", {63'b0, oor_flag}, 64'd0);
      for (int i = 0; i < depth[s]; i++) begin
        rd(win[s], d); check("R3 walk mem", d, pat(s, i));
      end
    end

    // R9 ignored fills left contents intact
    set_ptr(8, 0);
    rd(W0, d); check("R9 out-of-depth fill ignored", d, pat(0, 8));
    set_ptr(0, 0);
    for (int s = 0; s < 3; s++) begin
      rd(win[s], d); check("R9 select 3 ignored", d, pat(s, 0));
    end

    // R4 stride 7
    set_ptr(5, 7);
    for (int k = 0; k < 11; k++) begin
      rd(W1, d); check("R4 stride 7", d, pat(1, 5 + 7 * k));
    end

    // R4 16-bit wrap
    set_ptr(16'hFFFE, 3);
    rd(W2, d); check("R4 wrap oor", d, 64'd0);
    rd(W2, d); check("R4 wrapped position", d, pat(2, 1));

    // R5 simultaneous read and pointer write
    set_ptr(10, 1);
    @(negedge clk);
    csr_rd = 1'b1; csr_raddr = W1;
    csr_wr = 1'b1; csr_waddr = PTR; csr_wdata = {32'd0, 16'd2, 16'd100};
    @(negedge clk);
    csr_rd = 1'b0; csr_wr = 1'b0;
    check("R5 read uses old position", csr_rdata, pat(1, 10));
    rd(W1, d); check("R5 load beats increment", d, pat(1, 100));
    rd(W1, d); check("R5 new stride", d, pat(1, 102));

    // R8 clear and new oor in same cycle keeps flag
    set_ptr(40, 0);
    rd(W0, d);
    @(negedge clk);
    csr_rd = 1'b1; csr_raddr = W0;
    csr_wr = 1'b1; csr_waddr = PTR; csr_wdata = 64'd0;
    @(negedge clk);
    csr_rd = 1'b0; csr_wr = 1'b0;
    check("R8 set beats clear", {63'b0, oor_flag}, 64'd1);

    // R6 other reads and writes leave the pointer alone
    set_ptr(20, 1);
    rd(PTR, d); check("R6 pointer read", d, {32'd0, 16'd1, 16'd20});
    rd(16'h0200, d); check("R6 unmapped read zero", d, 64'd0);
    wr(W0, 64'h0000_0000_0005_0007);
    wr(16'h0020, 64'h0000_0000_0003_0003);
    rd(PTR, d); check("R6 pointer unchanged", d, {32'd0, 16'd1, 16'd20});
    rd(W0, d); check("R6 window after other accesses", d, pat(0, 20));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule